// File: doc/BRIEF.md
# Hash Engine Register and Interrupt Front-End

This block is the software-facing side of a multi-algorithm hash accelerator. It decodes a simple 32-bit register bus and keeps the configuration the hash core needs: a soft-reset control, the message length in bits as a 64-bit value, and a control word that selects the digest algorithm and the input byte order. These values drive the core directly. The core returns a single-cycle done pulse together with its full digest.

When the core finishes, the front-end captures the digest into a result queue. Software drains this queue one word per read. A read that finds the queue empty returns zero and raises its own status flag. A separate input from the data port reports payload writes that arrived before the block was configured. Sticky status bits, an enable mask and a write-one-to-clear register combine into one level interrupt line.

Software pulses the soft reset high and then low before each message. It then programs the length and the control word and streams the payload. When the interrupt fires, it drains the number of digest words that the chosen algorithm defines.

Top module: `hash_reg_frontend`

## Requirements
- R1: After the asynchronous reset every register reads 0, `irq_o` is 0, `core_srst_o` is 0 and `core_len_o` is 0.
- R2: Bit 0 of the soft-reset register (byte address 0x00) reads back as written and drives `core_srst_o`. While it is 1, the result queue is empty, the sticky status bits (0 to 3) are 0, and `core_done_i` and `early_wr_err_i` are ignored.
- R3: The length-high register (0x04) and the length-low register (0x08) read back as written. `core_len_o` is {high, low}.
- R4: In the control register (0x0C), bits [1:0] select the algorithm (0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256) and drive `core_alg_o`. Bits [9:8] select the byte order and drive `core_order_o`. All other bits read 0.
- R5: A `core_done_i` pulse loads the result queue with 4, 5, 7 or 8 digest words for algorithms 0, 1, 2 and 3, and sets status bits 0 (results available) and 1 (new results) on the same clock edge.
- R6: Each read of the result queue (0x1C) returns the next digest word, starting with word 0 (`core_digest_i[31:0]`) and rising in index, and removes that word from the queue.
- R7: A read of the result queue while it is empty returns 0 and sets status bit 2.
- R8: A pulse on `early_wr_err_i` sets status bit 3.
- R9: The status register is at 0x10. Bit 8 reads 1 exactly while the queue holds words. Writing a mask to the clear register (0x18) clears the matching sticky bits, but a bit whose event arrives in the same cycle stays set. The clear register reads 0.
- R10: `irq_o` is the OR over bits 0 to 3 and 8 of (status AND enable). The enable register is at 0x14, keeps only bits 0 to 3 and 8, and reads back as written.
- R11: Writes to the status register and to the result queue have no effect.
- R12: Read data appears on `bus_rdata` on the clock edge after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address; bits [4:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| core_srst_o | output | 1 | Soft reset to the hash core |
| core_alg_o | output | 2 | Algorithm select to the core |
| core_order_o | output | 2 | Byte-order select to the core |
| core_len_o | output | 64 | Message length in bits |
| core_done_i | input | 1 | Core finished, digest valid (one cycle) |
| core_digest_i | input | QDEPTH*32 | Digest words, word i at [32*i +: 32] |
| early_wr_err_i | input | 1 | Payload written before configuration |
| irq_o | output | 1 | Level interrupt |

## Verification
Several faults show up as a wrong pop order or a wrong drain length: a wrong read pointer, a wrong word count or a lost flush. The bench catches these on the first result-queue read after a done pulse, or on the extra read that must come back empty. A corrupted sticky or enable bit shows up as a wrong `irq_o` level within one cycle of the event. A clear that takes priority over an arriving event is caught by a status read two cycles later. Soft-reset faults appear on the first status or queue read taken while the reset is held.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned STAT_W   = 9;
    localparam int unsigned DIG_MAX  = 8;

    typedef enum logic [2:0] {
        REG_SRST   = 3'd0,
        REG_LEN_HI = 3'd1,
        REG_LEN_LO = 3'd2,
        REG_CTRL   = 3'd3,
        REG_STAT   = 3'd4,
        REG_IEN    = 3'd5,
        REG_ICLR   = 3'd6,
        REG_RQUEUE = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        ALG_MD5    = 2'd0,
        ALG_SHA1   = 2'd1,
        ALG_SHA224 = 2'd2,
        ALG_SHA256 = 2'd3
    } alg_e;

    localparam int unsigned ST_AVAIL   = 0;
    localparam int unsigned ST_NEW     = 1;
    localparam int unsigned ST_RDEMPTY = 2;
    localparam int unsigned ST_EARLYWR = 3;
    localparam int unsigned ST_LIVE    = 8;

    localparam logic [STAT_W-1:0] STICKY_MASK = 9'h00F;
    localparam logic [STAT_W-1:0] LIVE_MASK   = 9'h100;

    // Digest length in 32-bit words for each algorithm.
    function automatic int unsigned digest_words(alg_e a);
        case (a)
            ALG_MD5:    return 4;
            ALG_SHA1:   return 5;
            ALG_SHA224: return 7;
            default:    return 8;
        endcase
    endfunction
endpackage

// File: rtl/hrf_cfg_regs.sv
module hrf_cfg_regs
    import hrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic              srst_o,
    output logic [2*WORD_W-1:0] len_o,
    output alg_e              alg_o,
    output logic [1:0]        order_o
);
    typedef struct packed {
        logic              srst;
        logic [WORD_W-1:0] len_hi;
        logic [WORD_W-1:0] len_lo;
        alg_e              alg;
        logic [1:0]        order;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_sel)
                REG_SRST:   cfg_d.srst   = wr_data[0];
                REG_LEN_HI: cfg_d.len_hi = wr_data;
                REG_LEN_LO: cfg_d.len_lo = wr_data;
                REG_CTRL: begin
                    cfg_d.alg   = alg_e'(wr_data[1:0]);
                    cfg_d.order = wr_data[9:8];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign srst_o  = cfg_q.srst;
    assign len_o   = {cfg_q.len_hi, cfg_q.len_lo};
    assign alg_o   = cfg_q.alg;
    assign order_o = cfg_q.order;

    // R4: control outputs only move on a write
    assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(alg_o) && $stable(order_o)));
    // R3: length outputs only move on a write
    assert_len_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(len_o));
endmodule

// File: rtl/hrf_result_queue.sv
module hrf_result_queue #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     load,
    input  logic [$clog2(DEPTH+1)-1:0] load_cnt,
    input  logic [DEPTH*DW-1:0]      load_data,
    input  logic                     pop,
    output logic [DW-1:0]            head_o,
    output logic                     empty_o,
    output logic                     underflow_o
);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PTR_W-1:0]         rd_ptr;
        logic [CNT_W-1:0]         count;
    } rq_t;

    rq_t rq_d, rq_q;

    always_comb begin
        rq_d = rq_q;
        if (flush) begin
            rq_d.count  = '0;
            rq_d.rd_ptr = '0;
        end else if (load) begin
            for (int i = 0; i < DEPTH; i++) begin
                rq_d.mem[i] = load_data[i*DW +: DW];
            end
            rq_d.count  = load_cnt;
            rq_d.rd_ptr = '0;
        end else if (pop && (rq_q.count != '0)) begin
            rq_d.count  = rq_q.count - 1'b1;
            rq_d.rd_ptr = rq_q.rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rq_q <= '0;
        else        rq_q <= rq_d;
    end

    assign empty_o     = (rq_q.count == '0);
    assign head_o      = rq_q.mem[rq_q.rd_ptr];
    assign underflow_o = pop && empty_o && !flush && !load;

    // R5: a load fills exactly the requested number of words
    assert_load_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !flush) |=> (rq_q.count == $past(load_cnt)));
    // R6: each pop of a non-empty queue removes one word
    assert_pop_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !load && !flush && !empty_o) |=> (rq_q.count == $past(rq_q.count) - 1'b1));
endmodule

// File: rtl/hrf_irq_ctrl.sv
module hrf_irq_ctrl #(
    parameter int unsigned     W      = 9,
    parameter logic [W-1:0]    STICKY = 9'h00F,
    parameter logic [W-1:0]    LIVE   = 9'h100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic [W-1:0] set_i,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_mask,
    input  logic         en_wr,
    input  logic [W-1:0] en_data,
    input  logic [W-1:0] live_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] enable_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] sticky;
        logic [W-1:0] enable;
    } irq_t;

    irq_t ir_d, ir_q;
    logic [W-1:0] clr_eff;

    always_comb begin
        ir_d    = ir_q;
        clr_eff = clr_wr ? clr_mask : '0;
        if (flush) begin
            ir_d.sticky = '0;
        end else begin
            // an arriving event wins over a simultaneous clear
            ir_d.sticky = ((ir_q.sticky & ~clr_eff) | set_i) & STICKY;
        end
        if (en_wr) begin
            ir_d.enable = en_data & (STICKY | LIVE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ir_q <= '0;
        else        ir_q <= ir_d;
    end

    assign status_o = ir_q.sticky | (live_i & LIVE);
    assign enable_o = ir_q.enable;
    assign irq_o    = |(status_o & ir_q.enable);

    // R10: nothing enabled, no interrupt
    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_q.enable == '0) |-> !irq_o);
    // R9: events survive a same-cycle clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> ((ir_q.sticky & $past(set_i & STICKY)) == $past(set_i & STICKY)));
endmodule

// File: rtl/hash_reg_frontend.sv
module hash_reg_frontend
    import hrf_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned QDEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr_en,
    input  logic                     bus_rd_en,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic                     core_srst_o,
    output logic [1:0]               core_alg_o,
    output logic [1:0]               core_order_o,
    output logic [63:0]              core_len_o,
    input  logic                     core_done_i,
    input  logic [QDEPTH*32-1:0]     core_digest_i,
    input  logic                     early_wr_err_i,
    output logic                     irq_o
);
    localparam int unsigned CNT_W = $clog2(QDEPTH+1);

    // ---------------- address decode ----------------
    reg_sel_e sel;
    logic     hit;
    logic     addr_unused;

    assign sel         = reg_sel_e'(bus_addr[4:2]);
    assign addr_unused = ^bus_addr[1:0];

    generate
        if (ADDR_W > 5) begin : g_wide_addr
            assign hit = (bus_addr[ADDR_W-1:5] == '0);
        end else begin : g_exact_addr
            assign hit = 1'b1;
        end
    endgenerate

    logic wr, rd;
    assign wr = bus_wr_en && hit;
    assign rd = bus_rd_en && hit;

    // ---------------- configuration ----------------
    logic srst;
    alg_e alg;

    hrf_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr),
        .wr_sel  (sel),
        .wr_data (bus_wdata),
        .srst_o  (srst),
        .len_o   (core_len_o),
        .alg_o   (alg),
        .order_o (core_order_o)
    );

    assign core_srst_o = srst;
    assign core_alg_o  = alg;

    // ---------------- result queue ----------------
    logic              q_pop, q_empty, q_underflow, done_ev;
    logic [31:0]       q_head;
    logic [CNT_W-1:0]  q_words;

    assign done_ev = core_done_i && !srst;
    assign q_pop   = rd && (sel == REG_RQUEUE) && !srst;
    assign q_words = CNT_W'(digest_words(alg));

    hrf_result_queue #(.DW(32), .DEPTH(QDEPTH)) u_rq (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (srst),
        .load        (done_ev),
        .load_cnt    (q_words),
        .load_data   (core_digest_i),
        .pop         (q_pop),
        .head_o      (q_head),
        .empty_o     (q_empty),
        .underflow_o (q_underflow)
    );

    // ---------------- interrupt status ----------------
    logic [STAT_W-1:0] set_vec, live_vec, status, enable;

    always_comb begin
        set_vec             = '0;
        set_vec[ST_AVAIL]   = done_ev;
        set_vec[ST_NEW]     = done_ev;
        set_vec[ST_RDEMPTY] = q_underflow;
        set_vec[ST_EARLYWR] = early_wr_err_i && !srst;
        live_vec            = '0;
        live_vec[ST_LIVE]   = !q_empty;
    end

    hrf_irq_ctrl #(.W(STAT_W), .STICKY(STICKY_MASK), .LIVE(LIVE_MASK)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (srst),
        .set_i    (set_vec),
        .clr_wr   (wr && (sel == REG_ICLR)),
        .clr_mask (bus_wdata[STAT_W-1:0]),
        .en_wr    (wr && (sel == REG_IEN)),
        .en_data  (bus_wdata[STAT_W-1:0]),
        .live_i   (live_vec),
        .status_o (status),
        .enable_o (enable),
        .irq_o    (irq_o)
    );

    // ---------------- read path ----------------
    typedef struct packed {
        logic [31:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [31:0] rmux;

    always_comb begin
        rmux = '0;
        case (sel)
            REG_SRST:   rmux = {31'd0, srst};
            REG_LEN_HI: rmux = core_len_o[63:32];
            REG_LEN_LO: rmux = core_len_o[31:0];
            REG_CTRL:   rmux = {22'd0, core_order_o, 6'd0, alg};
            REG_STAT:   rmux = {{(32-STAT_W){1'b0}}, status};
            REG_IEN:    rmux = {{(32-STAT_W){1'b0}}, enable};
            REG_ICLR:   rmux = '0;
            REG_RQUEUE: rmux = (q_empty || srst) ? 32'd0 : q_head;
            default:    rmux = '0;
        endcase
        rd_d = rd_q;
        if (rd) rd_d.rdata = rmux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    // R2: a held soft reset leaves the queue empty
    assert_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> q_empty);
    // R5: done sets both result flags
    assert_done_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done_i && !srst) |=> (status[ST_AVAIL] && status[ST_NEW]));
    // R7: empty read raises its flag
    assert_empty_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (sel == REG_RQUEUE) && q_empty && !srst && !core_done_i) |=> status[ST_RDEMPTY]);
    // R8: early write error raises its flag
    assert_early_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (early_wr_err_i && !srst) |=> status[ST_EARLYWR]);
    // R12: read data holds without a read strobe
    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata));
endmodule

// File: tb/hash_reg_frontend_bench.sv
`timescale 1ns/1ps
module hash_reg_frontend_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr_en = 1'b0, bus_rd_en = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         core_srst_o;
    logic [1:0]   core_alg_o, core_order_o;
    logic [63:0]  core_len_o;
    logic         core_done_i = 1'b0;
    logic [255:0] core_digest_i = '0;
    logic         early_wr_err_i = 1'b0;
    logic         irq_o;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    hash_reg_frontend u_hash_reg_frontend (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_srst_o(core_srst_o), .core_alg_o(core_alg_o), .core_order_o(core_order_o),
        .core_len_o(core_len_o), .core_done_i(core_done_i), .core_digest_i(core_digest_i),
        .early_wr_err_i(early_wr_err_i), .irq_o(irq_o)
    );

    // table entries: {order[1:0], alg[1:0]}
    localparam logic [3:0] VEC [6] = '{4'b00_00, 4'b01_01, 4'b10_10, 4'b11_11, 4'b01_11, 4'b10_00};

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        core_done_i = 1'b1;
        @(negedge clk);
        core_done_i = 1'b0;
    endtask

    function automatic logic [31:0] pat(int t, int i);
        return 32'hC0DE0000 | 32'(t << 8) | 32'(i);
    endfunction

    function automatic int words_of(logic [1:0] a);
        case (a)
            2'd0: return 4;
            2'd1: return 5;
            2'd2: return 7;
            default: return 8;
        endcase
    endfunction

    task automatic set_digest(int t);
        for (int i = 0; i < 8; i++) core_digest_i[i*32 +: 32] = pat(t, i);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", irq_o, 0);
        check("R1 srst", core_srst_o, 0);
        check("R1 len", core_len_o, 0);
        rd(5'h00, d); check("R1 srst reg", d, 0);
        rd(5'h0C, d); check("R1 ctrl reg", d, 0);
        rd(5'h10, d); check("R1 status", d, 0);
        rd(5'h14, d); check("R1 enable", d, 0);

        // R3 length
        wr(5'h04, 32'h0000_0001); wr(5'h08, 32'h0000_0200);
        check("R3 len out", core_len_o, 64'h0000_0001_0000_0200);
        rd(5'h04, d); check("R3 hi", d, 32'h1);
        rd(5'h08, d); check("R3 lo", d, 32'h200);

        // R4 control field masking
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, d); check("R4 ctrl read", d, 32'h0000_0303);
        check("R4 alg", core_alg_o, 3);
        check("R4 order", core_order_o, 3);

        // R12 rdata holds without read
        repeat (3) @(negedge clk);
        check("R12 hold", bus_rdata, 32'h0000_0303);

        // table walk: R5 R6 R7 R9
        for (int t = 0; t < 6; t++) begin
            logic [1:0] a, o;
            int n;
            a = VEC[t][1:0]; o = VEC[t][3:2]; n = words_of(a);
            wr(5'h00, 1); wr(5'h00, 0);
            wr(5'h0C, {22'd0, o, 6'd0, a});
            check("R4 alg tbl", core_alg_o, a);
            check("R4 order tbl", core_order_o, o);
            set_digest(t);
            pulse_done();
            rd(5'h10, d); check("R5 flags", d, 32'h103);
            for (int i = 0; i < n; i++) begin
                rd(5'h1C, d); check("R6 pop", d, pat(t, i));
            end
            rd(5'h10, d); check("R9 live cleared", d, 32'h003);
            rd(5'h1C, d); check("R7 empty data", d, 0);
            rd(5'h10, d); check("R7 empty flag", d, 32'h007);
            wr(5'h18, 32'h1FF);
            rd(5'h10, d); check("R9 clear", d, 0);
        end

        // R11 writes to status and queue ignored
        wr(5'h0C, 32'h1); set_digest(9); pulse_done();
        wr(5'h10, 32'h0); wr(5'h1C, 32'hDEAD);
        rd(5'h10, d); check("R11 status write", d, 32'h103);
        rd(5'h1C, d); check("R11 queue write", d, pat(9, 0));
        rd(5'h18, d); check("R9 clr reads 0", d, 0);

        // R2 soft reset with queue loaded
        wr(5'h00, 1);
        check("R2 srst out", core_srst_o, 1);
        rd(5'h00, d); check("R2 srst read", d, 1);
        rd(5'h10, d); check("R2 flushed status", d, 0);
        pulse_done();
        @(negedge clk) early_wr_err_i = 1'b1;
        @(negedge clk) early_wr_err_i = 1'b0;
        rd(5'h10, d); check("R2 events ignored", d, 0);
        wr(5'h00, 0);
        check("R2 srst released", core_srst_o, 0);
        rd(5'h1C, d); check("R2 queue empty", d, 0);
        rd(5'h10, d); check("R7 after reset", d, 32'h004);
        wr(5'h18, 32'h4);

        // R8 / R9 event wins over simultaneous clear
        @(negedge clk);
        early_wr_err_i = 1'b1; bus_wr_en = 1'b1; bus_addr = 5'h18; bus_wdata = 32'h8;
        @(negedge clk);
        early_wr_err_i = 1'b0; bus_wr_en = 1'b0;
        rd(5'h10, d); check("R8 R9 set wins", d, 32'h008);
        wr(5'h18, 32'h8);
        rd(5'h10, d); check("R9 clear bit3", d, 0);

        // R10 interrupt
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h14, d); check("R10 enable mask", d, 32'h10F);
        wr(5'h14, 32'h2);
        check("R10 idle", irq_o, 0);
        wr(5'h0C, 32'h0); set_digest(3); pulse_done();
        check("R10 raised", irq_o, 1);
        wr(5'h18, 32'h2);
        check("R10 cleared", irq_o, 0);
        wr(5'h14, 32'h100);
        check("R10 live", irq_o, 1);
        wr(5'h00, 1); wr(5'h00, 0);
        check("R10 live gone", irq_o, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule